// File: doc/BRIEF.md
# I2C Controller Status and Interrupt Register

This block is the status byte of an I2C controller that works as either bus master or slave. The bit engine reports protocol events as one-cycle pulses. The register latches each pulse into a sticky flag that stays set until software clears it. The pulses cover the address acknowledge (master) or general call (slave), a finished byte, a detected STOP, being addressed as a slave, lost arbitration, and an ACK received in the ninth clock period. Two further bits are live copies of the bus-busy state and of the transmit/receive direction.

Software reads the byte through a plain read/write port. A write clears a sticky flag where the written bit is 0 and leaves it unchanged where the bit is 1. Five of the flags are interrupt sources, and their OR drives the interrupt line. While any source other than STOP-detected is pending, the block asks the engine to hold SCL low. The request drops only when every one of those flags has been cleared. All CPU and engine pins are plain control and status signals. No data stream crosses this block, so it has no valid/ready handshake.

Top module: `i2c_stat_reg`

## Requirements
- R1: After reset, all six sticky flags read 0, and `irq` and `scl_hold` are 0.
- R2: `rd_data` bit positions, from bit 7 down to bit 0, are: address-ack/general-call, byte-done, stop-detected, slave-selected, arbitration-lost, bus-busy, transmitting, ack-received. An engine pulse on a clock edge makes the matching flag read 1 after that edge.
- R3: The source of bit 7 depends on `master_mode`. When `master_mode` is 1, only `ev_addr_ack` sets it. When `master_mode` is 0, only `ev_gcall` sets it. The other pulse has no effect.
- R4: A write (`wr_en`=1) clears each sticky flag whose bit in `wr_data` is 0. A sticky flag whose written bit is 1 keeps its value.
- R5: If an engine pulse and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R6: Bits 2 and 1 always equal `bus_busy` and `is_tx`. Writes to those positions have no effect.
- R7: `irq` is 1 exactly when at least one of bits 7..3 is set.
- R8: `scl_hold` is 1 exactly when at least one of bits 7, 6, 4 or 3 is set. The stop-detected flag alone raises `irq` but not `scl_hold`.
- R9: The ack-received flag (bit 0) never raises `irq` or `scl_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write byte; 0 bits clear sticky flags |
| rd_data | output | 8 | Current register value |
| master_mode | input | 1 | 1 when the controller acts as master |
| ev_addr_ack | input | 1 | Pulse: slave acknowledged our address |
| ev_gcall | input | 1 | Pulse: general call address seen |
| ev_byte_done | input | 1 | Pulse: one byte transferred |
| ev_stop | input | 1 | Pulse: STOP condition seen |
| ev_slave_sel | input | 1 | Pulse: addressed by another master |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_ack_rx | input | 1 | Pulse: ACK sampled in ninth period |
| bus_busy | input | 1 | Live bus-busy state |
| is_tx | input | 1 | Live direction, 1 when transmitting |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
Each sticky flag is a single register that feeds `rd_data`, `irq` and `scl_hold` through combinational logic only. A wrong internal state therefore shows at the ports one clock after the event or write that caused it. A lost set, a clear that hits the wrong bit, or a wrong bit-7 source appears as a byte mismatch on `rd_data` in that same cycle. The error also shows as `irq` or `scl_hold` in the wrong state, and the wrong hold level would stall or release the bus. The bench compares all three outputs with a bench model after every cycle, so the first divergent cycle is reported.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned B_ADDR = 7;
  localparam int unsigned B_BYTE = 6;
  localparam int unsigned B_STOP = 5;
  localparam int unsigned B_SEL  = 4;
  localparam int unsigned B_ARB  = 3;
  localparam int unsigned B_BUSY = 2;
  localparam int unsigned B_TX   = 1;
  localparam int unsigned B_ACK  = 0;

  // which positions are sticky, interrupt sources, SCL-hold sources
  localparam logic [REG_W-1:0] STICKY_MASK = 8'b1111_1001;
  localparam logic [REG_W-1:0] IRQ_MASK    = 8'b1111_1000;
  localparam logic [REG_W-1:0] HOLD_MASK   = 8'b1101_1000;
endpackage

// File: rtl/i2c_stat_flag.sv
module i2c_stat_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk) begin
    if (!rst_n)      q <= 1'b0;
    else if (set_i)  q <= 1'b1;   // set beats clear
    else if (clr_i)  q <= 1'b0;
  end

  assign q_o = q;

  p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/i2c_stat_irq.sv
module i2c_stat_irq
  import i2c_stat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] flags_i,
  output logic             irq_o,
  output logic             hold_o
);
  assign irq_o  = |(flags_i & IRQ_MASK);
  assign hold_o = |(flags_i & HOLD_MASK);

  p_hold_needs_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> irq_o);
  p_stop_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_i & IRQ_MASK) == (REG_W'(1) << B_STOP)) |-> (irq_o && !hold_o));
endmodule

// File: rtl/i2c_stat_reg.sv
module i2c_stat_reg
  import i2c_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       master_mode,
  input  logic       ev_addr_ack,
  input  logic       ev_gcall,
  input  logic       ev_byte_done,
  input  logic       ev_stop,
  input  logic       ev_slave_sel,
  input  logic       ev_arb_lost,
  input  logic       ev_ack_rx,
  input  logic       bus_busy,
  input  logic       is_tx,
  output logic       irq,
  output logic       scl_hold
);
  logic [REG_W-1:0] ev_vec, live_vec, flags;

  always_comb begin
    ev_vec         = '0;
    ev_vec[B_ADDR] = master_mode ? ev_addr_ack : ev_gcall;
    ev_vec[B_BYTE] = ev_byte_done;
    ev_vec[B_STOP] = ev_stop;
    ev_vec[B_SEL]  = ev_slave_sel;
    ev_vec[B_ARB]  = ev_arb_lost;
    ev_vec[B_ACK]  = ev_ack_rx;
    live_vec         = '0;
    live_vec[B_BUSY] = bus_busy;
    live_vec[B_TX]   = is_tx;
  end

  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (STICKY_MASK[i]) begin : g_sticky
      i2c_stat_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_vec[i]),
        .clr_i (wr_en && !wr_data[i]),
        .q_o   (flags[i])
      );
    end else begin : g_live
      assign flags[i] = live_vec[i];
    end
  end

  assign rd_data = flags;

  i2c_stat_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flags),
    .irq_o   (irq),
    .hold_o  (scl_hold)
  );

  p_bit7_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && ev_addr_ack) |=> rd_data[B_ADDR]);
  p_live_after_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[B_BUSY] == bus_busy && rd_data[B_TX] == is_tx));
  p_ack_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ack_rx && ev_vec[7:3] == 5'd0 && rd_data[7:3] == 5'd0) |=> !irq);
endmodule

// File: tb/tb_i2c_stat_reg.sv
module tb_i2c_stat_reg;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [7:0] wr_data = 8'hFF;
  logic master_mode = 0, ev_addr_ack = 0, ev_gcall = 0, ev_byte_done = 0;
  logic ev_stop = 0, ev_slave_sel = 0, ev_arb_lost = 0, ev_ack_rx = 0;
  logic bus_busy = 0, is_tx = 0;
  logic [7:0] rd_data;
  logic irq, scl_hold;

  int total = 0, bad = 0;
  logic [7:0] m_flags = 8'h00;  // sticky bits only (7..3, 0)

  always #2 clk = ~clk;  // 250 MHz

  i2c_stat_reg dut (.*);

  function automatic logic [7:0] model_next(logic [7:0] f);
    logic [7:0] ev, nx;
    ev = {master_mode ? ev_addr_ack : ev_gcall, ev_byte_done, ev_stop,
          ev_slave_sel, ev_arb_lost, 2'b00, ev_ack_rx};
    nx = f;
    if (wr_en) nx = nx & (wr_data | 8'b0000_0110);
    nx = (nx | ev) & 8'b1111_1001;
    return nx;
  endfunction

  task automatic check(string tag);
    logic [7:0] exp_rd;
    logic exp_irq, exp_hold;
    exp_rd   = m_flags | {5'd0, bus_busy, is_tx, 1'b0};
    exp_irq  = |m_flags[7:3];
    exp_hold = m_flags[7] | m_flags[6] | m_flags[4] | m_flags[3];
    total++;
    if (rd_data !== exp_rd || irq !== exp_irq || scl_hold !== exp_hold) begin
      bad++;
      $display("FAIL %s rd=%h irq=%b hold=%b expected rd=%h irq=%b hold=%b",
               tag, rd_data, irq, scl_hold, exp_rd, exp_irq, exp_hold);
    end
  endtask

  task automatic clear_ev();
    wr_en = 0; wr_data = 8'hFF; ev_addr_ack = 0; ev_gcall = 0; ev_byte_done = 0;
    ev_stop = 0; ev_slave_sel = 0; ev_arb_lost = 0; ev_ack_rx = 0;
  endtask

  // apply current inputs for one edge, then check and drop pulses
  task automatic tick(string tag);
    @(posedge clk);
    m_flags = rst_n ? model_next(m_flags) : 8'h00;
    @(negedge clk);
    check(tag);
    clear_ev();
  endtask

  task automatic wr(logic [7:0] d, string tag);
    wr_en = 1; wr_data = d; tick(tag);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1");
    // R3: bit7 source by mode
    master_mode = 1; ev_gcall = 1; tick("R3 master ignores gcall");
    ev_addr_ack = 1; tick("R3 master addr ack");
    wr(8'h7F, "R4 clear bit7");
    master_mode = 0; ev_addr_ack = 1; tick("R3 slave ignores addr ack");
    ev_gcall = 1; tick("R3 slave gcall");
    // R4: write one keeps, write zero clears
    ev_byte_done = 1; tick("R2 byte done");
    wr(8'hFF, "R4 write ones keep");
    wr(8'hBF, "R4 clear byte done");
    wr(8'h00, "R4 clear all");
    // R5: set beats clear
    ev_byte_done = 1; tick("R5 prep");
    ev_byte_done = 1; wr(8'h00, "R5 set wins");
    wr(8'h00, "R5 cleanup");
    // R8: stop alone -> irq, no hold
    ev_stop = 1; tick("R8 stop alone");
    ev_arb_lost = 1; tick("R8 arb lost holds");
    wr(8'hF7, "R8 stop still irq");
    wr(8'h00, "R8 cleanup");
    // R9: rxack alone
    ev_ack_rx = 1; tick("R9 ack no irq");
    wr(8'hFE, "R4 clear ack");
    // R6: live bits and writes to them
    bus_busy = 1; is_tx = 1; wr(8'h00, "R6 live set");
    bus_busy = 0; is_tx = 1; wr(8'hFF, "R6 write ones");
    bus_busy = 0; is_tx = 0; tick("R6 live clear");
    ev_slave_sel = 1; tick("R7 sel irq");
    wr(8'hEF, "R7 sel cleared");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      master_mode  = $urandom_range(0, 1);
      bus_busy     = $urandom_range(0, 1);
      is_tx        = $urandom_range(0, 1);
      ev_addr_ack  = ($urandom_range(0, 7) == 0);
      ev_gcall     = ($urandom_range(0, 7) == 0);
      ev_byte_done = ($urandom_range(0, 7) == 0);
      ev_stop      = ($urandom_range(0, 7) == 0);
      ev_slave_sel = ($urandom_range(0, 7) == 0);
      ev_arb_lost  = ($urandom_range(0, 7) == 0);
      ev_ack_rx    = ($urandom_range(0, 7) == 0);
      wr_en        = ($urandom_range(0, 3) == 0);
      wr_data      = 8'($urandom);
      tick("R2 R7 R8 random");
    end
    // reset mid-run
    ev_byte_done = 1; tick("R2 pre reset");
    rst_n = 0; tick("R1 in reset");
    rst_n = 1; check("R1 after reset");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule